// File: doc/BRIEF.md
# Multi-Channel Tamper Event Controller

This block gathers tamper detections from five channels and an external event line and turns them into one sticky interrupt flag, a set of sticky source bits and a captured timestamp. Each channel carries a two-bit action. The action decides what happens when that channel fires: nothing happens, the flag is raised, or the flag is raised and the timestamp is taken. A fourth action runs an active-layer check. In that mode a 16-bit LFSR pattern is driven out of the block and the returned lines are compared with it on every debounce tick.

Software controls the block through a one-word write port with two targets. The control word holds the channel actions, the global detection enable and the external-event enable. The clear word clears source bits and the flag by writing 1 to them. When detection is switched on, interrupts are held back for ten clocks. Detections in that window are still recorded in the source bits and can still take the timestamp.

The block has no data stream. Every pin is a plain level or pulse, so there is no valid/ready handshake and no back-pressure.

Top module: `tamper_ctrl`

## Requirements
- R1: After reset, all source bits, the flag and the timestamp are 0, every action is off, detection is disabled and `al_out` equals the low five bits of the LFSR seed 0xACE1.
- R2: A channel whose action is 00 (off) ignores its detect pulse and its active-layer input, and no channel reacts while the enable (control bit 10) is 0.
- R3: A channel with action 01 (wake) sets its source bit and the flag on a detect pulse, and the timestamp is not changed.
- R4: A channel with action 10 (capture) sets its source bit and the flag on a detect pulse, and the timestamp takes the `cnt_val` value of that cycle.
- R5: A channel with action 11 (active layer) fires only in a cycle with `deb_tick` high and `al_in[i]` different from `al_out[i]`. It then sets its source bit and the flag and captures the timestamp. Its detect pulse is ignored.
- R6: Source bits are sticky. Writing the clear word (`wr_sel`=1) with bit i set clears bit i, for i = 0..5. A detection in the same cycle keeps the bit set.
- R7: There is one flag for all sources. Clear-word bit 6 clears it, and a new unmasked detection in the same cycle keeps it set.
- R8: `al_out[i]` is bit i of a 16-bit LFSR. On each `deb_tick` the LFSR steps to {s[14:0], s[15]^s[13]^s[12]^s[10]}. Without a tick it holds.
- R9: When the enable goes from 0 to 1, detections in the next 10 cycles set source bits but not the flag. A detection in the 11th cycle sets the flag.
- R10: An `evt_in` pulse sets source bit 5 and the flag and captures the timestamp, but only when both the enable and the event enable (control bit 11) are 1.
- R11: Several triggers in one cycle set every matching source bit and capture `cnt_val` once.
- R12: The control word's action field for channel i sits in bits [2i+1:2i]. Writes take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = clear word |
| wr_data | input | 12 | Write data |
| det_pulse | input | 5 | Per-channel detect pulses from debouncers |
| al_in | input | 5 | Returned active-layer lines |
| deb_tick | input | 1 | Debounce tick: compare and LFSR step |
| evt_in | input | 1 | External tamper event pulse |
| cnt_val | input | 32 | Free-running counter value |
| al_out | output | 5 | Driven active-layer pattern |
| tamper_id | output | 6 | Sticky source bits (bit 5 = external event) |
| tamper_irq | output | 1 | Shared tamper interrupt flag |
| timestamp | output | 32 | Captured counter value |

## Verification
Directed patterns walk each action on its own, so that off, wake, capture and active-layer can each be told apart by whether the flag and the timestamp move. Further directed cases cover:
- a clear written in the same cycle as a detection, which separates set-wins from clear-wins;
- detections in cycles 10 and 11 after enable, which pin down the mask boundary;
- an event with its enable off and then on.

A long random run then mixes writes, pulses, ticks and mismatches against a cycle model, which exposes ordering faults between the write, mask and capture paths.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  typedef enum logic [1:0] {
    ACT_OFF   = 2'b00,
    ACT_WAKE  = 2'b01,
    ACT_CAPT  = 2'b10,
    ACT_LAYER = 2'b11
  } act_e;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_CLR  = 1'b1;
endpackage

// File: rtl/tamper_lfsr.sv
module tamper_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  logic fb;

  assign fb = state[W-1] ^ state[W-3] ^ state[W-4] ^ state[W-6];

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/tamper_chan.sv
module tamper_chan
  import tamper_pkg::*;
(
  input  act_e act,
  input  logic enable,
  input  logic det,
  input  logic tick,
  input  logic al_in,
  input  logic al_ref,
  output logic trig,
  output logic cap
);
  logic mism;

  assign mism = tick && (al_in != al_ref);

  always_comb begin
    trig = 1'b0;
    cap  = 1'b0;
    if (enable) begin
      unique case (act)
        ACT_WAKE:  trig = det;
        ACT_CAPT:  begin trig = det;  cap = det;  end
        ACT_LAYER: begin trig = mism; cap = mism; end
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/tamper_mask.sv
module tamper_mask #(
  parameter int CYC   = 10,
  localparam int CW   = $clog2(CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  output logic          busy,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (arm)       cnt <= CW'(CYC);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/tamper_ctrl.sv
module tamper_ctrl
  import tamper_pkg::*;
#(
  parameter int            NCH      = 5,
  parameter int            TS_W     = 32,
  parameter int            LFSR_W   = 16,
  parameter logic [15:0]   SEED     = 16'hACE1,
  parameter int            MASK_CYC = 10,
  localparam int           DW       = 2 * NCH + 2,
  localparam int           IDW      = NCH + 1,
  localparam int           EN_BIT   = 2 * NCH,
  localparam int           EV_BIT   = 2 * NCH + 1,
  localparam int           IRQC_BIT = NCH + 1,
  localparam int           MCW      = $clog2(MASK_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic [NCH-1:0]  det_pulse,
  input  logic [NCH-1:0]  al_in,
  input  logic            deb_tick,
  input  logic            evt_in,
  input  logic [TS_W-1:0] cnt_val,
  output logic [NCH-1:0]  al_out,
  output logic [IDW-1:0]  tamper_id,
  output logic            tamper_irq,
  output logic [TS_W-1:0] timestamp
);
  logic [NCH-1:0][1:0] act_q;
  logic                en_q, ev_en_q;
  logic                wr_ctrl, wr_clr, arm;
  logic [NCH-1:0]      trig_vec, cap_vec;
  logic                evt_trig, trig_any, cap_any;
  logic [IDW-1:0]      new_id, clr_id;
  logic                mask_busy;
  logic [MCW-1:0]      mask_cnt;
  logic [LFSR_W-1:0]   lfsr_q;

  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
  assign wr_clr  = wr_en && (wr_sel == SEL_CLR);
  assign arm     = wr_ctrl && wr_data[EN_BIT] && !en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= '0;
      en_q    <= 1'b0;
      ev_en_q <= 1'b0;
    end else if (wr_ctrl) begin
      act_q   <= wr_data[2*NCH-1:0];
      en_q    <= wr_data[EN_BIT];
      ev_en_q <= wr_data[EV_BIT];
    end
  end

  tamper_lfsr #(.W(LFSR_W), .SEED(SEED[LFSR_W-1:0])) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (deb_tick),
    .state (lfsr_q)
  );

  assign al_out = lfsr_q[NCH-1:0];

  tamper_mask #(.CYC(MASK_CYC)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm),
    .busy  (mask_busy),
    .cnt   (mask_cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tamper_chan u_ch (
      .act    (act_e'(act_q[i])),
      .enable (en_q),
      .det    (det_pulse[i]),
      .tick   (deb_tick),
      .al_in  (al_in[i]),
      .al_ref (lfsr_q[i]),
      .trig   (trig_vec[i]),
      .cap    (cap_vec[i])
    );
  end

  assign evt_trig = en_q && ev_en_q && evt_in;
  assign new_id   = {evt_trig, trig_vec};
  assign trig_any = |new_id;
  assign cap_any  = (|cap_vec) || evt_trig;
  assign clr_id   = wr_clr ? wr_data[IDW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tamper_id  <= '0;
      tamper_irq <= 1'b0;
      timestamp  <= '0;
    end else begin
      tamper_id  <= (tamper_id & ~clr_id) | new_id;
      tamper_irq <= (tamper_irq && !(wr_clr && wr_data[IRQC_BIT]))
                    || (trig_any && !mask_busy);
      if (cap_any) timestamp <= cnt_val;
    end
  end
endmodule

// File: rtl/tamper_ctrl_chk.sv
module tamper_ctrl_chk #(
  parameter int NCH  = 5,
  parameter int TS_W = 32,
  parameter int MCW  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_clr,
  input logic            irq_clr,
  input logic            deb_tick,
  input logic [NCH-1:0]  al_out,
  input logic [NCH:0]    tamper_id,
  input logic            tamper_irq,
  input logic [TS_W-1:0] timestamp,
  input logic [MCW-1:0]  mask_cnt,
  input logic            trig_any,
  input logic            cap_any
);
  a_r6_id_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> ((tamper_id & $past(tamper_id)) == $past(tamper_id)));

  a_r4_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_any |=> $stable(timestamp));

  a_r8_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !deb_tick |=> $stable(al_out));

  a_r9_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_cnt != '0 && !tamper_irq) |=> !tamper_irq);

  a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && irq_clr && !trig_any) |=> !tamper_irq);

  a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_any && mask_cnt == '0) |=> tamper_irq);
endmodule

bind tamper_ctrl tamper_ctrl_chk #(.NCH(NCH), .TS_W(TS_W), .MCW(MCW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_clr     (wr_clr),
  .irq_clr    (wr_data[IRQC_BIT]),
  .deb_tick   (deb_tick),
  .al_out     (al_out),
  .tamper_id  (tamper_id),
  .tamper_irq (tamper_irq),
  .timestamp  (timestamp),
  .mask_cnt   (mask_cnt),
  .trig_any   (trig_any),
  .cap_any    (cap_any)
);

// File: tb/sim_tamper_ctrl.sv
module sim_tamper_ctrl;
  localparam int NCH  = 5;
  localparam int TS_W = 32;
  localparam int DW   = 2 * NCH + 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0, wr_sel = 1'b0;
  logic [DW-1:0]   wr_data = '0;
  logic [NCH-1:0]  det_pulse = '0, al_in = '0;
  logic            deb_tick = 1'b0, evt_in = 1'b0;
  logic [TS_W-1:0] cnt_val = '0;
  logic [NCH-1:0]  al_out;
  logic [NCH:0]    tamper_id;
  logic            tamper_irq;
  logic [TS_W-1:0] timestamp;

  always #4 clk = ~clk;

  tamper_ctrl u0 (.*);

  int checks = 0, errors = 0;

  logic [NCH-1:0][1:0] m_act = '0;
  logic            m_en = 0, m_ev = 0, m_irq = 0;
  logic [NCH:0]    m_id = '0;
  logic [TS_W-1:0] m_ts = '0;
  logic [15:0]     m_lfsr = 16'hACE1;
  int              m_mask = 0;

  function automatic logic [15:0] lfsr_next(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic we, logic sel, logic [DW-1:0] wd, logic [NCH-1:0] det,
                      logic [NCH-1:0] flip, logic tk, logic ev, logic [TS_W-1:0] cv);
    logic [NCH:0] nid;
    logic         cap;
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = wd; det_pulse = det;
    al_in = m_lfsr[NCH-1:0] ^ flip; deb_tick = tk; evt_in = ev; cnt_val = cv;
    nid = '0; cap = 0;
    for (int i = 0; i < NCH; i++) begin
      if (m_en) begin
        case (m_act[i])
          2'b01: nid[i] = det[i];
          2'b10: begin nid[i] = det[i]; cap |= det[i]; end
          2'b11: begin nid[i] = tk & flip[i]; cap |= tk & flip[i]; end
          default: ;
        endcase
      end
    end
    nid[NCH] = m_en & m_ev & ev;
    cap |= nid[NCH];
    m_irq = (m_irq && !(we && sel && wd[NCH+1])) || ((|nid) && m_mask == 0);
    m_id  = (m_id & ~((we && sel) ? wd[NCH:0] : '0)) | nid;
    if (cap) m_ts = cv;
    if (we && !sel && wd[2*NCH] && !m_en) m_mask = 10;
    else if (m_mask > 0) m_mask--;
    if (we && !sel) begin
      m_act = wd[2*NCH-1:0]; m_en = wd[2*NCH]; m_ev = wd[2*NCH+1];
    end
    if (tk) m_lfsr = lfsr_next(m_lfsr);
    @(posedge clk); #1;
    chk("R3/R6 tamper_id", 64'(tamper_id), 64'(m_id));
    chk("R7/R9 tamper_irq", 64'(tamper_irq), 64'(m_irq));
    chk("R4 timestamp", 64'(timestamp), 64'(m_ts));
    chk("R8 al_out", 64'(al_out), 64'(m_lfsr[NCH-1:0]));
    wr_en = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, '0, '0, '0, 0, 0, '0);
  endtask

  localparam logic [DW-1:0] ACTS = 12'h3F9;
  localparam logic [DW-1:0] ENB  = 12'h400;
  localparam logic [DW-1:0] EVB  = 12'h800;

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 id", 64'(tamper_id), 0);
    chk("R1 irq", 64'(tamper_irq), 0);
    chk("R1 ts", 64'(timestamp), 0);
    chk("R1 al_out", 64'(al_out), 64'h01);

    // R2 disabled: nothing reacts
    step(0, 0, '0, '1, '1, 1, 1, 32'h55);
    chk("R2 disabled id", 64'(tamper_id), 0);
    // R2 enabled but all off
    step(1, 0, ENB | EVB, '0, '0, 0, 0, '0);
    idle(12);
    step(0, 0, '0, 5'b01111, 5'b01111, 1, 0, 32'h77);
    chk("R2 off id", 64'(tamper_id), 0);
    chk("R2 off irq", 64'(tamper_irq), 0);

    // R12 actions: ch0 wake, ch1 capture, ch2..4 layer
    step(1, 0, ACTS | ENB, '0, '0, 0, 0, '0);
    step(0, 0, '0, 5'b00001, '0, 0, 0, 32'h1111);
    chk("R3 wake id", 64'(tamper_id), 64'h01);
    chk("R3 wake irq", 64'(tamper_irq), 1);
    chk("R3 wake ts", 64'(timestamp), 0);
    step(1, 1, 12'h07F, '0, '0, 0, 0, '0);
    chk("R6 clear id", 64'(tamper_id), 0);
    chk("R7 clear irq", 64'(tamper_irq), 0);
    step(0, 0, '0, 5'b00010, '0, 0, 0, 32'h2222);
    chk("R4 capture ts", 64'(timestamp), 64'h2222);
    chk("R12 capture id", 64'(tamper_id), 64'h02);
    step(0, 0, '0, 5'b00100, 5'b00100, 0, 0, 32'h9999);
    chk("R5 no tick id", 64'(tamper_id), 64'h02);
    step(0, 0, '0, '0, 5'b01000, 1, 0, 32'h3333);
    chk("R5 mismatch id", 64'(tamper_id), 64'h0A);
    chk("R5 mismatch ts", 64'(timestamp), 64'h3333);
    step(1, 1, 12'h07F, '0, '0, 0, 0, '0);
    step(0, 0, '0, 5'b00011, 5'b10000, 1, 0, 32'h4444);
    chk("R11 multi id", 64'(tamper_id), 64'h13);
    chk("R11 multi ts", 64'(timestamp), 64'h4444);
    step(1, 1, 12'h07F, 5'b00001, '0, 0, 0, '0);
    chk("R6 set wins", 64'(tamper_id), 64'h01);
    chk("R7 set wins", 64'(tamper_irq), 1);

    // R10 external event
    step(1, 1, 12'h07F, '0, '0, 0, 0, '0);
    step(0, 0, '0, '0, '0, 0, 1, 32'h5555);
    chk("R10 event off", 64'(tamper_id), 0);
    step(1, 0, ACTS | ENB | EVB, '0, '0, 0, 0, '0);
    step(0, 0, '0, '0, '0, 0, 1, 32'h6666);
    chk("R10 event id", 64'(tamper_id), 64'h20);
    chk("R10 event ts", 64'(timestamp), 64'h6666);

    // R9 mask window after re-enable
    step(1, 0, ACTS, '0, '0, 0, 0, '0);
    step(1, 1, 12'h07F, '0, '0, 0, 0, '0);
    step(1, 0, ACTS | ENB, '0, '0, 0, 0, '0);
    idle(9);
    step(0, 0, '0, 5'b00001, '0, 0, 0, '0);
    chk("R9 masked id", 64'(tamper_id), 64'h01);
    chk("R9 masked irq", 64'(tamper_irq), 0);
    step(0, 0, '0, 5'b00001, '0, 0, 0, '0);
    chk("R9 unmasked irq", 64'(tamper_irq), 1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic we, sel;
      logic [DW-1:0] wd;
      logic [NCH-1:0] det, flip;
      we = ($urandom % 10) == 0;
      sel = $urandom % 2;
      wd = DW'($urandom);
      if (we && !sel && ($urandom % 8) != 0) wd[2*NCH] = 1'b1;
      det = '0; flip = '0;
      for (int i = 0; i < NCH; i++) begin
        det[i]  = ($urandom % 8) == 0;
        flip[i] = ($urandom % 4) == 0;
      end
      step(we, sel, wd, det, flip, ($urandom % 4) == 0, ($urandom % 16) == 0, $urandom);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule